// File: doc/BRIEF.md
# Paged Character Video Generator

The block produces a monochrome character raster from a pixel clock of 25.2 MHz. A frame is 800 clocks by 525 lines. Inside the 640x480 visible region, a field of 80 columns by 51 rows of 8x8 cells (640x408 pixels) is centred vertically. There are 36 blank visible lines above the field and 36 below it. Character codes sit in a 4096-byte dual-port buffer. The display side reads the buffer on its own port. The host reaches it only through a 1024-byte window, and a 2-bit page register places that window on one quarter of the buffer.

For every cell, the display pipeline computes the buffer address three clocks ahead of the cell. It reads the code and presents the code with the cell line to an external glyph lookup, which returns the 8-bit glyph row combinationally in the same cycle. On the last pixel of the cell before, the pipeline loads that row into a shift register. Pixels leave most significant bit first. Horizontal and vertical sync are active low. A visible-region flag qualifies the pixel output.

In the requirements below, h is the pixel count within a line and v is the line count within a frame. Both start at 0 at the top-left visible pixel. All geometry is set by parameters; the figures quoted are the defaults.

Top module: `txtvid_top`

## Requirements
- R1: A line lasts H_TOT = 800 clocks. hsync_n is low for exactly 96 clocks, for h from 656 to 751, and high at every other h.
- R2: A frame lasts 525 lines. vsync_n is low for lines 490 and 491 only, and changes level only at h = 0.
- R3: video_active is 1 exactly when h < 640 and v < 480. Neither sync is low while it is 1.
- R4: pixel is 0 whenever h >= 640, or v < 36, or v >= 36 + 51*8 = 444.
- R5: Inside the character field, let row = (v-36)/8, line = (v-36) mod 8 and col = h/8. pixel equals bit (7 - h mod 8) of font_bits returned for font_code = buffer[row*80 + col] and font_line = line. Bit 7 is therefore the leftmost pixel of a cell.
- R6: A host write with bus_we = 1 and bus_addr[10] = 0 stores bus_wdata at buffer address page*1024 + bus_addr[9:0].
- R7: A host read, with bus_we = 0 and bus_addr[10] = 0, returns on bus_rdata, one clock after the address is presented, the byte at page*1024 + bus_addr[9:0]. A read in the cycle after a write to the same location returns the new byte.
- R8: A write with bus_addr[10] = 1 sets the page to bus_wdata[1:0] and ignores bus_wdata[7:2]. A read with bus_addr[10] = 1 returns the page in bits 1:0 and zeros in bits 7:2.
- R9: After reset the page is 0, hsync_n and vsync_n are 1, and pixel is 0. The first clock after reset release is pixel h = 0, v = 0, so video_active is 1 there.
- R10: Buffer addresses 4080 to 4095 keep host data and can be read back, but never reach the screen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 11 | Host address; bit 10 selects the page register, bits 9:0 the window offset |
| bus_we | input | 1 | Host write strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, one clock after the address |
| font_code | output | 8 | Character code sent to the glyph lookup |
| font_line | output | 3 | Cell line sent to the glyph lookup |
| font_bits | input | 8 | Glyph row returned combinationally by the lookup |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| video_active | output | 1 | High inside the visible region |
| pixel | output | 1 | Monochrome pixel |

## Verification
The assertions assume one host access per clock, with the address and strobe held stable around each rising edge. They also assume that font_bits settles within the cycle from font_code and font_line. The bench drives the bus only at falling edges and models the glyph lookup as a pure function of its two inputs. The pixel comparison assumes the buffer is not written during the frame being compared. For that reason, all host traffic, including page changes and random read-back, is confined to the first frame, and every pixel is compared in the second frame.

// File: rtl/txtvid_pkg.sv
package txtvid_pkg;
    localparam int GLYPH_W     = 8;
    localparam int FONT_LINE_W = 3;
    localparam int DATA_W      = 8;
    localparam int WIN_AW      = 10;
    localparam int PAGE_W      = 2;
    localparam int BUF_AW      = WIN_AW + PAGE_W;
    localparam int BUS_AW      = WIN_AW + 1;
    localparam int LOOKAHEAD   = 3;

    typedef enum logic {
        SEL_WINDOW = 1'b0,
        SEL_PAGE   = 1'b1
    } bus_sel_e;
endpackage

// File: rtl/txtvid_timing.sv
module txtvid_timing #(
    parameter int H_ACT  = 640,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_VIS  = 480,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 33,
    localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP,
    localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
    localparam int HW    = $clog2(H_TOT),
    localparam int VW    = $clog2(V_TOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] h_o,
    output logic [VW-1:0] v_o,
    output logic          hsync_n_o,
    output logic          vsync_n_o,
    output logic          vis_o
);
    localparam int HS_START = H_ACT + H_FP;
    localparam int HS_END   = HS_START + H_SYNC;
    localparam int VS_START = V_VIS + V_FP;
    localparam int VS_END   = VS_START + V_SYNC;

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } scan_t;

    scan_t scan_d, scan_q;

    always_comb begin
        scan_d = scan_q;
        if (int'(scan_q.h) == H_TOT - 1) begin
            scan_d.h = '0;
            if (int'(scan_q.v) == V_TOT - 1) begin
                scan_d.v = '0;
            end else begin
                scan_d.v = scan_q.v + 1'b1;
            end
        end else begin
            scan_d.h = scan_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_q <= '0;
        end else begin
            scan_q <= scan_d;
        end
    end

    assign h_o       = scan_q.h;
    assign v_o       = scan_q.v;
    assign hsync_n_o = !(int'(scan_q.h) >= HS_START && int'(scan_q.h) < HS_END);
    assign vsync_n_o = !(int'(scan_q.v) >= VS_START && int'(scan_q.v) < VS_END);
    assign vis_o     = (int'(scan_q.h) < H_ACT) && (int'(scan_q.v) < V_VIS);
endmodule

// File: rtl/txtvid_charram.sv
module txtvid_charram
    import txtvid_pkg::*;
#(
    localparam int DEPTH = 1 << BUF_AW
) (
    input  logic              clk,
    input  logic              a_we,
    input  logic [BUF_AW-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic [BUF_AW-1:0] b_addr,
    output logic [DATA_W-1:0] b_rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (a_we) begin
            mem_q[a_addr] <= a_wdata;
        end
        a_rdata <= mem_q[a_addr];
    end

    always_ff @(posedge clk) begin
        b_rdata <= mem_q[b_addr];
    end
endmodule

// File: rtl/txtvid_busif.sv
module txtvid_busif
    import txtvid_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              ram_we_o,
    output logic [BUF_AW-1:0] ram_addr_o,
    output logic [DATA_W-1:0] ram_wdata_o,
    input  logic [DATA_W-1:0] ram_rdata_i
);
    typedef struct packed {
        logic [PAGE_W-1:0] page;
        bus_sel_e          sel;
    } bus_st_t;

    bus_st_t  st_d, st_q;
    bus_sel_e sel_now;

    always_comb begin
        sel_now = bus_addr_i[WIN_AW] ? SEL_PAGE : SEL_WINDOW;
        st_d     = st_q;
        st_d.sel = sel_now;
        if (bus_we_i && sel_now == SEL_PAGE) begin
            st_d.page = bus_wdata_i[PAGE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{page: '0, sel: SEL_WINDOW};
        end else begin
            st_q <= st_d;
        end
    end

    assign ram_we_o    = bus_we_i && (sel_now == SEL_WINDOW);
    assign ram_addr_o  = {st_q.page, bus_addr_i[WIN_AW-1:0]};
    assign ram_wdata_o = bus_wdata_i;
    assign bus_rdata_o = (st_q.sel == SEL_PAGE) ? DATA_W'(st_q.page) : ram_rdata_i;
endmodule

// File: rtl/txtvid_fetch.sv
module txtvid_fetch
    import txtvid_pkg::*;
#(
    parameter int COLS   = 80,
    parameter int ROWS   = 51,
    parameter int CELL_H = 8,
    parameter int H_TOT  = 800,
    parameter int V_TOT  = 525,
    parameter int V_TOP  = 36,
    localparam int HW         = $clog2(H_TOT),
    localparam int VW         = $clog2(V_TOT),
    localparam int HW1        = HW + 1,
    localparam int H_ACT      = COLS * GLYPH_W,
    localparam int LINE_W     = $clog2(CELL_H),
    localparam int CHAR_LINES = ROWS * CELL_H
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [HW-1:0]          h_i,
    input  logic [VW-1:0]          v_i,
    output logic [BUF_AW-1:0]      ram_addr_o,
    input  logic [DATA_W-1:0]      ram_rdata_i,
    output logic [DATA_W-1:0]      font_code_o,
    output logic [FONT_LINE_W-1:0] font_line_o,
    input  logic [GLYPH_W-1:0]     font_bits_i,
    output logic                   pixel_o
);
    localparam logic [2:0] PH_FETCH = 3'd5;
    localparam logic [2:0] PH_LOOK  = 3'd6;
    localparam logic [2:0] PH_LOAD  = 3'd7;

    typedef struct packed {
        logic                   tag_vld;
        logic [FONT_LINE_W-1:0] tag_line;
        logic [GLYPH_W-1:0]     glyph;
        logic [GLYPH_W-1:0]     shift;
    } fetch_st_t;

    fetch_st_t        st_d, st_q;
    logic [HW1-1:0]   h_ahead;
    logic [VW-1:0]    v_ahead;
    logic [VW-1:0]    rel;
    logic [VW-1:0]    row;
    logic [HW1-1:0]   col;
    logic             tgt_ok;

    always_comb begin
        h_ahead = {1'b0, h_i} + HW1'(LOOKAHEAD);
        v_ahead = v_i;
        if (int'(h_ahead) >= H_TOT) begin
            h_ahead = h_ahead - HW1'(H_TOT);
            if (int'(v_i) == V_TOT - 1) begin
                v_ahead = '0;
            end else begin
                v_ahead = v_i + 1'b1;
            end
        end
        rel    = v_ahead - VW'(V_TOP);
        row    = rel >> LINE_W;
        col    = h_ahead >> 3;
        tgt_ok = (int'(h_ahead) < H_ACT) && (int'(v_ahead) >= V_TOP)
                 && (int'(v_ahead) < V_TOP + CHAR_LINES);
    end

    assign ram_addr_o = BUF_AW'(row) * BUF_AW'(COLS) + BUF_AW'(col);

    always_comb begin
        st_d = st_q;
        if (h_i[2:0] == PH_FETCH) begin
            st_d.tag_vld  = tgt_ok;
            st_d.tag_line = FONT_LINE_W'(rel[LINE_W-1:0]);
        end
        if (h_i[2:0] == PH_LOOK) begin
            st_d.glyph = st_q.tag_vld ? font_bits_i : '0;
        end
        if (h_i[2:0] == PH_LOAD) begin
            st_d.shift = st_q.glyph;
        end else begin
            st_d.shift = {st_q.shift[GLYPH_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign font_code_o = ram_rdata_i;
    assign font_line_o = st_q.tag_line;
    assign pixel_o     = st_q.shift[GLYPH_W-1];
endmodule

// File: rtl/txtvid_top.sv
module txtvid_top
    import txtvid_pkg::*;
#(
    parameter int COLS   = 80,
    parameter int ROWS   = 51,
    parameter int CELL_H = 8,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_TOP  = 36,
    parameter int V_BOT  = 36,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 33,
    localparam int H_ACT = COLS * GLYPH_W,
    localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP,
    localparam int V_VIS = V_TOP + ROWS * CELL_H + V_BOT,
    localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
    localparam int HW    = $clog2(H_TOT),
    localparam int VW    = $clog2(V_TOT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [BUS_AW-1:0]      bus_addr,
    input  logic                   bus_we,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic [DATA_W-1:0]      font_code,
    output logic [FONT_LINE_W-1:0] font_line,
    input  logic [GLYPH_W-1:0]     font_bits,
    output logic                   hsync_n,
    output logic                   vsync_n,
    output logic                   video_active,
    output logic                   pixel
);
    logic [HW-1:0]     h_cnt;
    logic [VW-1:0]     v_cnt;
    logic              host_we;
    logic [BUF_AW-1:0] host_addr;
    logic [DATA_W-1:0] host_wdata;
    logic [DATA_W-1:0] host_rdata;
    logic [BUF_AW-1:0] disp_addr;
    logic [DATA_W-1:0] disp_rdata;

    txtvid_timing #(
        .H_ACT (H_ACT), .H_FP (H_FP), .H_SYNC (H_SYNC), .H_BP (H_BP),
        .V_VIS (V_VIS), .V_FP (V_FP), .V_SYNC (V_SYNC), .V_BP (V_BP)
    ) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .h_o       (h_cnt),
        .v_o       (v_cnt),
        .hsync_n_o (hsync_n),
        .vsync_n_o (vsync_n),
        .vis_o     (video_active)
    );

    txtvid_busif u_busif (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr_i  (bus_addr),
        .bus_we_i    (bus_we),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .ram_we_o    (host_we),
        .ram_addr_o  (host_addr),
        .ram_wdata_o (host_wdata),
        .ram_rdata_i (host_rdata)
    );

    txtvid_charram u_ram (
        .clk     (clk),
        .a_we    (host_we),
        .a_addr  (host_addr),
        .a_wdata (host_wdata),
        .a_rdata (host_rdata),
        .b_addr  (disp_addr),
        .b_rdata (disp_rdata)
    );

    txtvid_fetch #(
        .COLS (COLS), .ROWS (ROWS), .CELL_H (CELL_H),
        .H_TOT (H_TOT), .V_TOT (V_TOT), .V_TOP (V_TOP)
    ) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .h_i         (h_cnt),
        .v_i         (v_cnt),
        .ram_addr_o  (disp_addr),
        .ram_rdata_i (disp_rdata),
        .font_code_o (font_code),
        .font_line_o (font_line),
        .font_bits_i (font_bits),
        .pixel_o     (pixel)
    );
endmodule

// File: rtl/txtvid_chk.sv
module txtvid_chk #(
    parameter int HW     = 10,
    parameter int VW     = 10,
    parameter int H_TOT  = 800,
    parameter int H_SYNC = 96,
    parameter int V_TOP  = 36,
    parameter int CHAR_LINES = 408
) (
    input logic          clk,
    input logic          rst_n,
    input logic [HW-1:0] h_cnt,
    input logic [VW-1:0] v_cnt,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic          video_active,
    input logic          pixel,
    input logic [10:0]   bus_addr,
    input logic          bus_we,
    input logic [7:0]    bus_rdata
);
    logic [15:0] hs_low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_low_q <= '0;
        end else if (!hsync_n) begin
            hs_low_q <= hs_low_q + 1'b1;
        end else begin
            hs_low_q <= '0;
        end
    end

    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(h_cnt) == H_TOT - 1) |=> (h_cnt == '0)); // R1

    AST_HSYNC_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_n) |-> (int'(hs_low_q) == H_SYNC)); // R1

    AST_VSYNC_AT_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(vsync_n) || $rose(vsync_n)) |-> (h_cnt == '0)); // R2

    AST_ACTIVE_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        video_active |-> (hsync_n && vsync_n)); // R3

    AST_PIX_BLANK_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !video_active |-> !pixel); // R4

    AST_PIX_BLANK_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(v_cnt) < V_TOP) || (int'(v_cnt) >= V_TOP + CHAR_LINES)) |-> !pixel); // R4

    AST_PAGE_READ_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[10] && !bus_we) |=> (bus_rdata[7:2] == 6'd0)); // R8
endmodule

bind txtvid_top txtvid_chk #(
    .HW (HW), .VW (VW), .H_TOT (H_TOT), .H_SYNC (H_SYNC),
    .V_TOP (V_TOP), .CHAR_LINES (ROWS * CELL_H)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .h_cnt        (h_cnt),
    .v_cnt        (v_cnt),
    .hsync_n      (hsync_n),
    .vsync_n      (vsync_n),
    .video_active (video_active),
    .pixel        (pixel),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_rdata    (bus_rdata)
);

// File: tb/tb_txtvid_top.sv
module tb_txtvid_top;
    localparam int CLK_PERIOD = 40;
    localparam int COLS = 80, ROWS = 51, CELL_H = 2;
    localparam int H_FP = 8, H_SYNC = 16, H_BP = 8;
    localparam int V_TOP = 2, V_BOT = 2, V_FP = 2, V_SYNC = 2, V_BP = 2;
    localparam int H_ACT = COLS * 8;
    localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
    localparam int V_VIS = V_TOP + ROWS * CELL_H + V_BOT;
    localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  font_code;
    logic [2:0]  font_line;
    logic [7:0]  font_bits;
    logic        hsync_n, vsync_n, video_active, pixel;

    int nvec = 0;
    int nerr = 0;
    int bh = 0, bv = 0, fcnt = 0;
    logic [7:0] shadow [4096];

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] glyph(input logic [7:0] code, input logic [2:0] line);
        return (code ^ (8'(line) * 8'd37)) + 8'(line);
    endfunction

    assign font_bits = glyph(font_code, font_line);

    txtvid_top #(
        .COLS (COLS), .ROWS (ROWS), .CELL_H (CELL_H),
        .H_FP (H_FP), .H_SYNC (H_SYNC), .H_BP (H_BP),
        .V_TOP (V_TOP), .V_BOT (V_BOT), .V_FP (V_FP), .V_SYNC (V_SYNC), .V_BP (V_BP)
    ) dut (
        .clk (clk), .rst_n (rst_n),
        .bus_addr (bus_addr), .bus_we (bus_we), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .font_code (font_code), .font_line (font_line), .font_bits (font_bits),
        .hsync_n (hsync_n), .vsync_n (vsync_n), .video_active (video_active), .pixel (pixel)
    );

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d (h=%0d v=%0d)", req, act, exp, bh, bv);
        end
    endtask

    function automatic int exp_pixel(input int h, input int v);
        int row, line, col;
        logic [7:0] g;
        if (h >= H_ACT || v < V_TOP || v >= V_TOP + ROWS * CELL_H) return 0;
        row  = (v - V_TOP) / CELL_H;
        line = (v - V_TOP) % CELL_H;
        col  = h / 8;
        g    = glyph(shadow[row * COLS + col], 3'(line));
        return int'(g[7 - (h % 8)]);
    endfunction

    // bench position model: advances with the design on every clock out of reset
    always @(posedge clk) begin
        if (!rst_n) begin
            bh <= 0; bv <= 0;
        end else if (bh == H_TOT - 1) begin
            bh <= 0;
            if (bv == V_TOT - 1) begin
                bv <= 0;
                fcnt <= fcnt + 1;
            end else begin
                bv <= bv + 1;
            end
        end else begin
            bh <= bh + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && fcnt < 2) begin
            chk("R1 hsync_n", int'(hsync_n),
                (bh >= H_ACT + H_FP && bh < H_ACT + H_FP + H_SYNC) ? 0 : 1);
            chk("R2 vsync_n", int'(vsync_n),
                (bv >= V_VIS + V_FP && bv < V_VIS + V_FP + V_SYNC) ? 0 : 1);
            chk("R3 video_active", int'(video_active), (bh < H_ACT && bv < V_VIS) ? 1 : 0);
            if (fcnt == 1) begin
                // R4 blanking, R5 glyph path, R10 hidden tail never shown
                chk("R5 pixel", int'(pixel), exp_pixel(bh, bv));
            end else if (bh >= H_ACT || bv < V_TOP || bv >= V_TOP + ROWS * CELL_H) begin
                chk("R4 pixel blank", int'(pixel), 0);
            end
        end
    end

    task automatic bus_write(input logic [10:0] a, input logic [7:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [10:0] a, input int exp, input string req);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        chk(req, int'(bus_rdata), exp);
    endtask

    initial begin
        int pages [4] = '{2, 0, 3, 1};
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R9 reset hsync_n", int'(hsync_n), 1);
        chk("R9 reset vsync_n", int'(vsync_n), 1);
        chk("R9 reset pixel", int'(pixel), 0);
        rst_n = 1'b1;
        bus_read(11'h400, 0, "R9 reset page");
        // fill the whole buffer page by page in a scrambled order
        foreach (pages[i]) begin
            logic [7:0] junk = 8'($urandom) & 8'hFC;
            bus_write(11'h400, junk | 8'(pages[i]));
            bus_read(11'h400, pages[i], "R8 page readback");
            for (int o = 0; o < 1024; o++) begin
                logic [7:0] d = 8'($urandom);
                if (pages[i] == 3 && o >= 1008) d = 8'hFF;
                bus_write(11'(o), d);
                shadow[pages[i] * 1024 + o] = d;
            end
        end
        // random read-back through random pages
        for (int k = 0; k < 300; k++) begin
            int p = int'($urandom % 4);
            int o = int'($urandom % 1024);
            bus_write(11'h400, 8'(p));
            bus_read(11'(o), int'(shadow[p * 1024 + o]), "R6 R7 window read");
        end
        // hidden tail of the buffer keeps data
        bus_write(11'h400, 8'd3);
        bus_write(11'h3FF, 8'h5A);
        shadow[4095] = 8'h5A;
        bus_read(11'h3FF, 8'h5A, "R10 tail readback");
        bus_read(11'h3F0, 8'hFF, "R10 tail readback");
        // read immediately after a write to the same cell
        bus_write(11'h3FE, 8'hA7);
        shadow[4094] = 8'hA7;
        bus_read(11'h3FE, 8'hA7, "R7 read after write");
        // first and last displayed cells
        bus_write(11'h400, 8'd0);
        bus_write(11'h000, 8'h81);
        shadow[0] = 8'h81;
        bus_write(11'h400, 8'd3);
        bus_write(11'h3EF, 8'h3C);
        shadow[4079] = 8'h3C;
        bus_read(11'h3EF, 8'h3C, "R6 last cell write");
        bus_read(11'h400, 3, "R8 page after writes");
        bus_write(11'h400, 8'hFE);
        bus_read(11'h400, 2, "R8 upper data bits ignored");
        while (fcnt < 2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule